// File: doc/BRIEF.md
# Radix-4 State-Metric Recursion Unit

This block advances the forward or backward state metrics of a trellis decoder by one radix-4 step per enabled clock. It handles a trellis of up to eight states. Each state has four incoming transitions. For each transition, the block adds the metric of a predecessor state to a branch metric. It then reduces the four candidates with a tree of table-corrected max-star operators and normalises the result against state 0. The result is saturated into the metric width and stored in a register. That register feeds the next step.

Which predecessor feeds each candidate is set per state by a routing input. The same datapath therefore serves several trellis structures. When merging is on, the branch metric of a candidate is the sum of two single-step branch metrics. This folds two binary trellis steps into one cycle. When merging is off, the first branch metric is used as it is, as duo-binary symbols need. A load pulse sets the metrics either to a known start in state 0 or to an all-equal start for the acquisition pass of a tail-biting code.

Top module: `r4sm_unit`

## Requirements
- R1: While reset is asserted and after it is released, the metric of state 0 reads 0 and every other state reads -(2^(MW-2)), which is -256 at the default width.
- R2: A load pulse with init_mode_i=0 sets state 0 to 0 and the other states to -(2^(MW-2)). A load pulse with init_mode_i=1 sets every state to 0. A load takes effect on the next edge and wins over a step in the same cycle.
- R3: With neither load nor step asserted, the metric output holds its value whatever the routing and branch inputs do.
- R4: Candidate j of state s uses the predecessor index at sel_i bits [(4s+j)*S +: S], with S = clog2(NS). The candidate is the current metric of that predecessor plus the branch term of candidate j, where branch fields are at bits [(4s+j)*BW +: BW], two's complement.
- R5: With merge_i=1 the branch term is bm_first + bm_second. With merge_i=0 it is bm_first alone, and bm_second has no effect on the output.
- R6: A two-input max-star returns the larger input plus a correction taken from the absolute difference d: 2 for d <= 1, 1 for 2 <= d <= 5, 0 for d >= 6.
- R7: The raw metric of a state is maxstar(maxstar(c0,c1), maxstar(c2,c3)).
- R8: After a step, each state reads its raw metric minus the raw metric of state 0, so state 0 reads 0.
- R9: A normalised value above 2^(MW-1)-1 is clamped to that value, and one below -2^(MW-1) is clamped to that value. Values never wrap.
- R10: The new metrics appear on metric_o right after the clock edge that samples step_i, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Initialise metrics on this edge |
| init_mode_i | input | 1 | 0: known start in state 0; 1: all states equal |
| step_i | input | 1 | Advance one radix-4 step |
| merge_i | input | 1 | 1: branch term is the sum of both branch inputs |
| sel_i | input | NS*4*clog2(NS) | Predecessor index per state and candidate |
| bm_first_i | input | NS*4*BW | First branch metric per state and candidate |
| bm_second_i | input | NS*4*BW | Second branch metric per state and candidate |
| metric_o | output | NS*MW | Current state metrics, state s at [s*MW +: MW] |

## Verification
The bench sweeps the difference between two competing candidates across every band of the correction table. An off-by-one band edge would then show up as a metric one or two units away from the expected value. It drives opposing extremes into state 0 and the other states, so that normalised values land far beyond both rails. A design that wrapped instead of clamping would flip the sign of the stored metric. It changes the second branch input while merging is off and applies simultaneous load and step. These catch a design that leaks the unused operand or lets the step win. A long run with random routing and random merging then catches a wrong predecessor selection or a misordered reduction tree.

// File: rtl/r4sm_pkg.sv
package r4sm_pkg;

  typedef enum logic {
    INIT_KNOWN   = 1'b0,
    INIT_ACQUIRE = 1'b1
  } init_mode_e;

  localparam int CORR_W = 2;

  // Table correction of the max-star operator, indexed by |a-b| (R6)
  function automatic logic [CORR_W-1:0] ms_corr(input int mag);
    if (mag <= 1)      return CORR_W'(2);
    else if (mag <= 5) return CORR_W'(1);
    else               return CORR_W'(0);
  endfunction

endpackage

// File: rtl/r4sm_maxstar2.sv
module r4sm_maxstar2
  import r4sm_pkg::*;
#(
  parameter int W = 13
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] y_o
);

  logic signed [W:0]    diff;
  logic        [W:0]    mag;
  logic signed [W-1:0]  larger;
  logic [CORR_W-1:0]    corr;

  always_comb begin
    diff   = (W+1)'(a_i) - (W+1)'(b_i);
    larger = diff[W] ? b_i : a_i;
    mag    = diff[W] ? (W+1)'(-diff) : (W+1)'(diff);
    corr   = ms_corr(int'(mag));
    y_o    = larger + W'(corr);
  end

endmodule

// File: rtl/r4sm_acsa.sv
module r4sm_acsa #(
  parameter int NS = 8,
  parameter int MW = 10,
  parameter int BW = 10,
  parameter int CW = 13
) (
  input  logic [NS*MW-1:0]          metric_i,
  input  logic [4*$clog2(NS)-1:0]   sel_i,
  input  logic [4*BW-1:0]           bm_a_i,
  input  logic [4*BW-1:0]           bm_b_i,
  input  logic                      merge_i,
  output logic signed [CW-1:0]      raw_o
);

  localparam int SW = $clog2(NS);

  logic signed [CW-1:0] cand [4];
  logic signed [CW-1:0] pair_lo;
  logic signed [CW-1:0] pair_hi;

  for (genvar j = 0; j < 4; j++) begin : g_cand
    logic [SW-1:0]        pred;
    logic signed [MW-1:0] pm;
    logic signed [BW-1:0] ba;
    logic signed [BW-1:0] bb;
    logic signed [CW-1:0] branch;
    always_comb begin
      pred    = sel_i[j*SW +: SW];
      pm      = metric_i[pred*MW +: MW];
      ba      = bm_a_i[j*BW +: BW];
      bb      = bm_b_i[j*BW +: BW];
      branch  = merge_i ? (CW'(ba) + CW'(bb)) : CW'(ba);
      cand[j] = CW'(pm) + branch;
    end
  end

  r4sm_maxstar2 #(.W(CW)) u_ms_lo   (.a_i(cand[0]), .b_i(cand[1]), .y_o(pair_lo));
  r4sm_maxstar2 #(.W(CW)) u_ms_hi   (.a_i(cand[2]), .b_i(cand[3]), .y_o(pair_hi));
  r4sm_maxstar2 #(.W(CW)) u_ms_root (.a_i(pair_lo), .b_i(pair_hi), .y_o(raw_o));

endmodule

// File: rtl/r4sm_norm.sv
module r4sm_norm #(
  parameter int NS = 8,
  parameter int MW = 10,
  parameter int CW = 13
) (
  input  logic [NS*CW-1:0] raw_i,
  output logic [NS*MW-1:0] metric_o,
  output logic [NS-1:0]    sat_o
);

  localparam int MAXV = (1 << (MW-1)) - 1;
  localparam int MINV = -(1 << (MW-1));

  logic signed [CW-1:0] ref_raw;
  assign ref_raw = raw_i[0 +: CW];

  for (genvar s = 0; s < NS; s++) begin : g_norm
    logic signed [CW-1:0] own;
    logic signed [CW:0]   d;
    always_comb begin
      own = raw_i[s*CW +: CW];
      d   = (CW+1)'(own) - (CW+1)'(ref_raw);
      if (d > MAXV) begin
        metric_o[s*MW +: MW] = MW'(MAXV);
        sat_o[s] = 1'b1;
      end else if (d < MINV) begin
        metric_o[s*MW +: MW] = MW'(MINV);
        sat_o[s] = 1'b1;
      end else begin
        metric_o[s*MW +: MW] = d[MW-1:0];
        sat_o[s] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/r4sm_unit.sv
module r4sm_unit
  import r4sm_pkg::*;
#(
  parameter int NS = 8,
  parameter int MW = 10,
  parameter int BW = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       init_mode_i,
  input  logic                       step_i,
  input  logic                       merge_i,
  input  logic [NS*4*$clog2(NS)-1:0] sel_i,
  input  logic [NS*4*BW-1:0]         bm_first_i,
  input  logic [NS*4*BW-1:0]         bm_second_i,
  output logic [NS*MW-1:0]           metric_o
);

  localparam int SW       = $clog2(NS);
  localparam int CW       = ((MW > BW) ? MW : BW) + 3;
  localparam int NEG_INIT = -(1 << (MW-2));

  init_mode_e           mode;
  logic [NS*MW-1:0]     metric_q;
  logic [NS*MW-1:0]     init_known;
  logic [NS*MW-1:0]     init_acq;
  logic [NS*MW-1:0]     next_metric;
  logic [NS*CW-1:0]     raw_flat;
  logic [NS-1:0]        sat_vec;
  logic                 sat_any;

  assign mode    = init_mode_e'(init_mode_i);
  assign sat_any = |sat_vec;

  for (genvar s = 0; s < NS; s++) begin : g_state
    assign init_known[s*MW +: MW] = (s == 0) ? '0 : MW'(NEG_INIT);
    assign init_acq[s*MW +: MW]   = '0;

    r4sm_acsa #(.NS(NS), .MW(MW), .BW(BW), .CW(CW)) u_acsa (
      .metric_i (metric_q),
      .sel_i    (sel_i[s*4*SW +: 4*SW]),
      .bm_a_i   (bm_first_i[s*4*BW +: 4*BW]),
      .bm_b_i   (bm_second_i[s*4*BW +: 4*BW]),
      .merge_i  (merge_i),
      .raw_o    (raw_flat[s*CW +: CW])
    );
  end

  r4sm_norm #(.NS(NS), .MW(MW), .CW(CW)) u_norm (
    .raw_i    (raw_flat),
    .metric_o (next_metric),
    .sat_o    (sat_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      metric_q <= init_known;
    else if (load_i)
      metric_q <= (mode == INIT_ACQUIRE) ? init_acq : init_known;
    else if (step_i)
      metric_q <= next_metric;
  end

  assign metric_o = metric_q;

endmodule

// File: rtl/r4sm_unit_chk.sv
module r4sm_unit_chk #(
  parameter int NS = 8,
  parameter int MW = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             init_mode_i,
  input logic             step_i,
  input logic [NS*MW-1:0] metric_o,
  input logic             sat_any
);

  localparam int MAXV     = (1 << (MW-1)) - 1;
  localparam int MINV     = -(1 << (MW-1));
  localparam int NEG_INIT = -(1 << (MW-2));

  logic ext_any;
  always_comb begin
    ext_any = 1'b0;
    for (int s = 0; s < NS; s++)
      if (metric_o[s*MW +: MW] == MW'(MAXV) || metric_o[s*MW +: MW] == MW'(MINV))
        ext_any = 1'b1;
  end

  for (genvar s = 0; s < NS; s++) begin : g_init
    p_known_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !init_mode_i) |=>
        (metric_o[s*MW +: MW] == ((s == 0) ? MW'(0) : MW'(NEG_INIT))));
    p_acq_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && init_mode_i) |=> (metric_o[s*MW +: MW] == MW'(0)));
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(metric_o));

  p_state0_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (metric_o[0 +: MW] == MW'(0)));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && sat_any) |=> ext_any);

endmodule

bind r4sm_unit r4sm_unit_chk #(.NS(NS), .MW(MW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .init_mode_i (init_mode_i),
  .step_i      (step_i),
  .metric_o    (metric_o),
  .sat_any     (sat_any)
);

// File: tb/r4sm_unit_test.sv
`timescale 1ns/1ps
module r4sm_unit_test;

  localparam int NS = 8;
  localparam int MW = 10;
  localparam int BW = 10;
  localparam int SW = 3;
  localparam int HI = 511;
  localparam int LO = -512;
  localparam int NEGI = -256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0, init_mode_i = 1'b0, step_i = 1'b0, merge_i = 1'b0;
  logic [NS*4*SW-1:0] sel_i = '0;
  logic [NS*4*BW-1:0] bm_first_i = '0, bm_second_i = '0;
  logic [NS*MW-1:0]   metric_o;

  always #4 clk = ~clk;

  r4sm_unit #(.NS(NS), .MW(MW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .init_mode_i(init_mode_i),
    .step_i(step_i), .merge_i(merge_i), .sel_i(sel_i),
    .bm_first_i(bm_first_i), .bm_second_i(bm_second_i), .metric_o(metric_o)
  );

  int em [NS];
  int selv [NS][4];
  int b1 [NS][4];
  int b2 [NS][4];
  bit mrg;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic int ref_corr(int m);
    case (m)
      0, 1:       return 2;
      2, 3, 4, 5: return 1;
      default:    return 0;
    endcase
  endfunction

  function automatic int ref_ms(int a, int b);
    int d = (a >= b) ? a - b : b - a;
    return ((a >= b) ? a : b) + ref_corr(d);
  endfunction

  task automatic ref_step();
    int raw [NS];
    int c [4];
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j < 4; j++)
        c[j] = em[selv[s][j]] + b1[s][j] + (mrg ? b2[s][j] : 0);
      raw[s] = ref_ms(ref_ms(c[0], c[1]), ref_ms(c[2], c[3]));
    end
    for (int s = 0; s < NS; s++) begin
      int v = raw[s] - raw[0];
      em[s] = (v > HI) ? HI : ((v < LO) ? LO : v);
    end
  endtask

  task automatic pack();
    for (int s = 0; s < NS; s++)
      for (int j = 0; j < 4; j++) begin
        sel_i[(s*4+j)*SW +: SW]       = selv[s][j][SW-1:0];
        bm_first_i[(s*4+j)*BW +: BW]  = b1[s][j][BW-1:0];
        bm_second_i[(s*4+j)*BW +: BW] = b2[s][j][BW-1:0];
      end
    merge_i = mrg;
  endtask

  task automatic compare(string tag);
    for (int s = 0; s < NS; s++) begin
      int act = int'($signed(metric_o[s*MW +: MW]));
      checks++;
      if (act !== em[s]) begin
        fails++;
        $display("FAIL %s state %0d: actual %0d expected %0d", tag, s, act, em[s]);
      end
    end
  endtask

  task automatic do_step(string tag);
    @(negedge clk);
    pack();
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    ref_step();
    compare(tag);
  endtask

  task automatic do_load(bit acq, string tag);
    @(negedge clk);
    load_i = 1'b1;
    init_mode_i = acq;
    @(negedge clk);
    load_i = 1'b0;
    for (int s = 0; s < NS; s++) em[s] = acq ? 0 : ((s == 0) ? 0 : NEGI);
    compare(tag);
  endtask

  function automatic int rnd_bm();
    return int'($urandom_range(0, 1023)) - 512;
  endfunction

  task automatic fill_all(int v);
    for (int s = 0; s < NS; s++)
      for (int j = 0; j < 4; j++) begin
        selv[s][j] = 0; b1[s][j] = v; b2[s][j] = 0;
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NS; s++) em[s] = (s == 0) ? 0 : NEGI;
    fill_all(0);
    mrg = 0;
    #10;
    compare("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R3: idle with moving inputs
    for (int k = 0; k < 6; k++) begin
      for (int s = 0; s < NS; s++)
        for (int j = 0; j < 4; j++) begin
          selv[s][j] = int'($urandom_range(0, 7)); b1[s][j] = rnd_bm(); b2[s][j] = rnd_bm();
        end
      mrg = k[0];
      pack();
      @(negedge clk);
      compare("R3 hold");
    end

    // R2: both init modes, and load winning over step
    do_load(1, "R2 acquire load");
    do_load(0, "R2 known load");
    @(negedge clk);
    load_i = 1'b1; init_mode_i = 1'b1; step_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
    for (int s = 0; s < NS; s++) em[s] = 0;
    compare("R2 load over step");

    // R6/R10: sweep the candidate gap over every correction band
    for (int k = 0; k < 9; k++) begin
      do_load(1, "R2 acquire load");
      fill_all(LO);
      for (int j = 0; j < 4; j++) b1[0][j] = 0;
      for (int s = 1; s < NS; s++) begin
        b1[s][0] = 0;
        b1[s][1] = -(k + s - 1);
      end
      mrg = 0;
      do_step("R6 max-star gap sweep");
    end

    // R7/R4: distinct candidates through different predecessors
    for (int k = 0; k < 8; k++) begin
      do_load(0, "R2 known load");
      for (int s = 0; s < NS; s++)
        for (int j = 0; j < 4; j++) begin
          selv[s][j] = (s + j + k) % NS;
          b1[s][j] = (j * 7 + s * 3 + k) % 40 - 20;
          b2[s][j] = 0;
        end
      mrg = 0;
      do_step("R7 tree order");
      do_step("R4 routing");
    end

    // R5: second operand ignored with merge off, summed with merge on
    for (int k = 0; k < 10; k++) begin
      for (int s = 0; s < NS; s++)
        for (int j = 0; j < 4; j++) begin
          selv[s][j] = int'($urandom_range(0, 7));
          b1[s][j] = int'($urandom_range(0, 60)) - 30;
          b2[s][j] = rnd_bm();
        end
      mrg = k[0];
      do_step(mrg ? "R5 merged branch" : "R5 second ignored");
    end

    // R9: both rails
    do_load(1, "R2 acquire load");
    fill_all(HI);
    for (int j = 0; j < 4; j++) begin b1[0][j] = LO; b2[0][j] = LO; end
    for (int j = 0; j < 4; j++) b2[1][j] = HI;
    mrg = 1;
    do_step("R9 upper clamp");
    do_load(1, "R2 acquire load");
    fill_all(LO);
    for (int j = 0; j < 4; j++) begin b1[0][j] = HI; b2[0][j] = HI; end
    for (int s = 1; s < NS; s++) for (int j = 0; j < 4; j++) b2[s][j] = LO;
    mrg = 1;
    do_step("R9 lower clamp");

    // R8/R4/R5: long random run
    for (int n = 0; n < 1500; n++) begin
      if (n % 97 == 0) do_load(n[0], "R2 periodic load");
      for (int s = 0; s < NS; s++)
        for (int j = 0; j < 4; j++) begin
          selv[s][j] = int'($urandom_range(0, 7));
          b1[s][j] = (n % 3 == 0) ? rnd_bm() : int'($urandom_range(0, 80)) - 40;
          b2[s][j] = int'($urandom_range(0, 80)) - 40;
        end
      mrg = ($urandom_range(0, 1) == 1);
      do_step("R8 random step");
    end

    finish_run();
  end

endmodule